// File: doc/BRIEF.md
# Queued-Idle Serial Transmitter

This block is the transmit half of an asynchronous serial port. Software writes an 8-bit control word and a data byte. The block moves the byte into a shift register and sends it as a framed character, one bit per baud tick. It can also send two special characters. An idle character is ten bit-times high. It is requested by turning the transmit enable off and back on while a character is still going out. A break character is ten bit-times low, and it keeps repeating for as long as the break-request bit stays set.

The block decides whether it owns the transmit pin or hands it back to the general-purpose port. It takes the pin in normal mode. It gives the pin up in internal loopback mode. In single-wire half-duplex mode it follows a direction input. When the enable is cleared, the pin stays owned until the current character and every queued character have finished. Two transmit-side interrupt sources are combined onto a single request line, and each source has its own mask.

Top module: `sertx_top`

## Requirements
- R1: The control word has these bits: bit 7 data-empty interrupt enable, bit 6 complete interrupt enable, bit 5 receive interrupt enable, bit 4 idle-line interrupt enable, bit 3 transmit enable, bit 2 receive enable, bit 1 receiver wake-up, bit 0 break request. All bits reset to 0. A write takes effect on the next cycle, and the full word can always be read back on `ctl_rdata`.
- R2: A data character is one low start bit, then the 8 data bits least significant bit first, then one high stop bit. Each bit lasts from one `baud_tick` to the next. A character may only start on a tick, and `tx_line` changes only on a tick.
- R3: `irq` is high exactly when (bit 7 and `empty`) or (bit 6 and `done`) is true.
- R4: `empty` is 1 after reset. It clears the cycle after a data write. It sets when the held byte is moved into the shifter. If a write and a move happen in the same cycle, the write wins.
- R5: `done` is 1 after reset. It clears when any character starts. It sets when the shifter stops and nothing else can start.
- R6: A held byte is moved into the shifter only while transmit enable is 1. With the enable at 0, the byte waits and `empty` stays 0.
- R7: A control write that raises transmit enable while a character is shifting queues one idle character of ten high bit-times.
- R8: A control write that raises the break-request bit queues one break character of ten low bit-times. If the bit is still 1 when a break ends, another break follows at once.
- R9: When the shifter is free, or a character ends on a tick, the next character is chosen in this order: break, then idle, then data.
- R10: In normal mode (`mode_loop`=0), `tx_oe` is 1 while transmit enable is 1, while a character is shifting, or while an idle or break character is queued. Otherwise it is 0.
- R11: In loopback mode (`mode_loop`=1, `mode_single`=0), `tx_oe` is 0 whatever the enable and shifter state.
- R12: In single-wire mode (`mode_loop`=1, `mode_single`=1), `tx_oe` equals the R10 ownership condition ANDed with `line_dir`.
- R13: `tx_line` is high whenever no character is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Single-cycle pulse at the bit rate |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write value |
| ctl_rdata | output | 8 | Current control word |
| data_wr | input | 1 | Data byte write strobe |
| data_wdata | input | 8 | Data byte to send |
| mode_loop | input | 1 | Selects loopback or single-wire operation |
| mode_single | input | 1 | With `mode_loop`, selects single-wire operation |
| line_dir | input | 1 | Single-wire direction, 1 = drive |
| tx_line | output | 1 | Serial bit stream for the pin and for the loopback path |
| tx_oe | output | 1 | Pin owned and driven by the transmitter |
| empty | output | 1 | Data holding byte is free |
| done | output | 1 | Transmission complete |
| irq | output | 1 | Masked transmit interrupt request |

## Verification
The line-stability check assumes that `baud_tick` is a pulse of one cycle and that its spacing is longer than one clock. The bench therefore makes a tick every fourth clock. Mode pins are treated as static configuration. The bench changes them only when a change is part of the scenario, and always half a clock away from the edge, so the ownership check in normal mode sees settled values. Control and data writes are single-cycle strobes driven on the falling edge. Scenarios place them while a character is shifting, so the idle and break queues are loaded mid-frame as the queuing requirements describe.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    CH_NONE = 2'd0,
    CH_DATA = 2'd1,
    CH_IDLE = 2'd2,
    CH_BRK  = 2'd3
  } ch_kind_t;

  localparam int CTL_W  = 8;
  localparam int B_TXIE = 7;
  localparam int B_TCIE = 6;
  localparam int B_RIE  = 5;
  localparam int B_ILIE = 4;
  localparam int B_TEN  = 3;
  localparam int B_REN  = 2;
  localparam int B_RWU  = 1;
  localparam int B_BRK  = 0;
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             empty,
  input  logic             done,
  output logic [CTL_W-1:0] ctl_q,
  output logic             ten,
  output logic             brk,
  output logic             ten_rise,
  output logic             brk_rise,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_wdata;
  end

  assign ten      = ctl_q[B_TEN];
  assign brk      = ctl_q[B_BRK];
  assign ten_rise = ctl_wr & ctl_wdata[B_TEN] & ~ctl_q[B_TEN];
  assign brk_rise = ctl_wr & ctl_wdata[B_BRK] & ~ctl_q[B_BRK];
  assign irq      = (ctl_q[B_TXIE] & empty) | (ctl_q[B_TCIE] & done);

  assert_ctl_write_R1: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (ctl_q == $past(ctl_wdata)));
endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              load,
  output logic [DATA_W-1:0] dbuf,
  output logic              empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dbuf  <= '0;
      empty <= 1'b1;
    end else begin
      if (data_wr) begin
        dbuf  <= data_wdata;
        empty <= 1'b0;
      end else if (load) begin
        empty <= 1'b1;
      end
    end
  end

  assert_empty_clear_R4: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> !empty);
endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              ten,
  input  logic              brk,
  input  logic              ten_rise,
  input  logic              brk_rise,
  input  logic              have_data,
  input  logic [DATA_W-1:0] dbuf,
  output logic              line,
  output logic              busy,
  output logic              pend,
  output logic              load_data,
  output logic              done
);
  localparam int LAST  = DATA_W + 1;
  localparam int CNT_W = $clog2(DATA_W + 2);

  ch_kind_t          kind;
  logic [CNT_W-1:0]  idx;
  logic [DATA_W-1:0] sh;
  logic              idle_q, brk_q;
  logic              last, start_ok, want_brk;
  logic              take_brk, take_idle, take_data;

  always_comb begin
    last      = busy && (int'(idx) == LAST);
    start_ok  = baud_tick && (!busy || last);
    want_brk  = brk_q || (busy && kind == CH_BRK && brk);
    take_brk  = start_ok && want_brk;
    take_idle = start_ok && !want_brk && idle_q;
    take_data = start_ok && !want_brk && !idle_q && ten && have_data;
  end

  assign load_data = take_data;
  assign pend      = idle_q | brk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      kind   <= CH_NONE;
      idx    <= '0;
      sh     <= '0;
      line   <= 1'b1;
      idle_q <= 1'b0;
      brk_q  <= 1'b0;
      done   <= 1'b1;
    end else begin
      idle_q <= (idle_q && !take_idle) || (ten_rise && busy);
      brk_q  <= (brk_q && !take_brk) || brk_rise;
      if (take_brk || take_idle || take_data) begin
        busy <= 1'b1;
        idx  <= '0;
        done <= 1'b0;
        kind <= take_brk ? CH_BRK : (take_idle ? CH_IDLE : CH_DATA);
        line <= take_idle;
        sh   <= dbuf;
      end else if (baud_tick && busy) begin
        if (last) begin
          busy <= 1'b0;
          kind <= CH_NONE;
          line <= 1'b1;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
          case (kind)
            CH_DATA: begin
              if (int'(idx) < DATA_W) begin
                line <= sh[0];
                sh   <= sh >> 1;
              end else begin
                line <= 1'b1;
              end
            end
            CH_IDLE: line <= 1'b1;
            default: line <= 1'b0;
          endcase
        end
      end
    end
  end

  assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !baud_tick |=> $stable(line));
  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_free_high_R13: assert property (@(posedge clk) disable iff (rst)
    !busy |-> line);
endmodule

// File: rtl/sertx_pin.sv
module sertx_pin (
  input  logic ten,
  input  logic busy,
  input  logic pend,
  input  logic mode_loop,
  input  logic mode_single,
  input  logic line_dir,
  output logic oe
);
  logic own;
  assign own = ten | busy | pend;

  always_comb begin
    if (!mode_loop)       oe = own;
    else if (!mode_single) oe = 1'b0;
    else                  oe = own & line_dir;
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              mode_loop,
  input  logic              mode_single,
  input  logic              line_dir,
  output logic              tx_line,
  output logic              tx_oe,
  output logic              empty,
  output logic              done,
  output logic              irq
);
  logic              ten, brk, ten_rise, brk_rise;
  logic              busy, pend, load_data;
  logic [DATA_W-1:0] dbuf;

  sertx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .empty(empty), .done(done), .ctl_q(ctl_rdata), .ten(ten), .brk(brk),
    .ten_rise(ten_rise), .brk_rise(brk_rise), .irq(irq)
  );

  sertx_dbuf #(.DATA_W(DATA_W)) u_dbuf (
    .clk(clk), .rst(rst), .data_wr(data_wr), .data_wdata(data_wdata),
    .load(load_data), .dbuf(dbuf), .empty(empty)
  );

  sertx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .ten(ten), .brk(brk),
    .ten_rise(ten_rise), .brk_rise(brk_rise), .have_data(!empty),
    .dbuf(dbuf), .line(tx_line), .busy(busy), .pend(pend),
    .load_data(load_data), .done(done)
  );

  sertx_pin u_pin (
    .ten(ten), .busy(busy), .pend(pend), .mode_loop(mode_loop),
    .mode_single(mode_single), .line_dir(line_dir), .oe(tx_oe)
  );

  assert_pin_held_R10: assert property (@(posedge clk) disable iff (rst)
    (!mode_loop && busy) |-> tx_oe);
  assert_irq_source_R3: assert property (@(posedge clk) disable iff (rst)
    irq |-> (empty || done));
  assert_data_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(empty) |-> $past(ten));
endmodule

// File: tb/sertx_top_bench.sv
module sertx_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       data_wr = 1'b0;
  logic [7:0] data_wdata = '0;
  logic       mode_loop = 1'b0, mode_single = 1'b0, line_dir = 1'b0;
  logic       tx_line, tx_oe, empty, done, irq;

  always #10 clk = ~clk;

  sertx_top u_sertx_top (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .data_wr(data_wr),
    .data_wdata(data_wdata), .mode_loop(mode_loop), .mode_single(mode_single),
    .line_dir(line_dir), .tx_line(tx_line), .tx_oe(tx_oe), .empty(empty),
    .done(done), .irq(irq)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R2";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // tick generator: one pulse every fourth clock
  int tcnt = 0;
  always @(negedge clk) begin
    if (rst) begin
      tcnt <= 0;
      baud_tick <= 1'b0;
    end else begin
      tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
      baud_tick <= (tcnt == 3);
    end
  end

  // behavioural reference: 0 none, 1 data, 2 idle, 3 break
  logic [7:0] m_ctl, m_buf, m_byte;
  int m_busy, m_kind, m_idx, m_iq, m_bq, m_done, m_empty;

  function automatic int m_line();
    if (m_busy == 0) return 1;
    if (m_kind == 3) return 0;
    if (m_kind == 2) return 1;
    if (m_idx == 0) return 0;
    if (m_idx == 9) return 1;
    return int'(m_byte[m_idx-1]);
  endfunction

  function automatic int m_oe();
    int own;
    own = (m_ctl[3] || m_busy != 0 || m_iq != 0 || m_bq != 0) ? 1 : 0;
    if (!mode_loop) return own;
    if (!mode_single) return 0;
    return own & int'(line_dir);
  endfunction

  function automatic int m_quiet();
    return (m_busy == 0 && m_iq == 0 && m_bq == 0 &&
            (m_empty != 0 || !m_ctl[3])) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int ob, tr, br, st, wb, tk;
    if (rst) begin
      m_ctl = '0; m_buf = '0; m_byte = '0;
      m_busy = 0; m_kind = 0; m_idx = 0; m_iq = 0; m_bq = 0;
      m_done = 1; m_empty = 1;
    end else begin
      ob = m_busy;
      tr = (ctl_wr && ctl_wdata[3] && !m_ctl[3]) ? 1 : 0;
      br = (ctl_wr && ctl_wdata[0] && !m_ctl[0]) ? 1 : 0;
      st = (baud_tick && (m_busy == 0 || m_idx == 9)) ? 1 : 0;
      wb = (m_bq != 0 || (m_busy != 0 && m_kind == 3 && m_ctl[0])) ? 1 : 0;
      tk = 0;
      if (st != 0) begin
        if (wb != 0) tk = 3;
        else if (m_iq != 0) tk = 2;
        else if (m_ctl[3] && m_empty == 0) tk = 1;
      end
      if (tk != 0) begin
        m_busy = 1; m_kind = tk; m_idx = 0; m_done = 0;
        if (tk == 1) begin m_byte = m_buf; m_empty = 1; end
        if (tk == 2) m_iq = 0;
        if (tk == 3) m_bq = 0;
      end else if (baud_tick && m_busy != 0) begin
        if (m_idx == 9) begin m_busy = 0; m_kind = 0; m_done = 1; end
        else m_idx++;
      end
      if (tr != 0 && ob != 0) m_iq = 1;
      if (br != 0) m_bq = 1;
      if (data_wr) begin m_buf = data_wdata; m_empty = 0; end
      if (ctl_wr) m_ctl = ctl_wdata;
    end
  end

  // compare quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (!rst) begin
      check(int'(tx_line) == m_line(), cur_req, "tx_line", int'(tx_line), m_line());
      check(int'(tx_oe) == m_oe(), mode_loop ? (mode_single ? "R12" : "R11") : "R10",
            "tx_oe", int'(tx_oe), m_oe());
      check(int'(empty) == m_empty, "R4", "empty", int'(empty), m_empty);
      check(int'(done) == m_done, "R5", "done", int'(done), m_done);
      check(int'(irq) == ((m_ctl[7] && m_empty != 0) || (m_ctl[6] && m_done != 0) ? 1 : 0),
            "R3", "irq", int'(irq),
            (m_ctl[7] && m_empty != 0) || (m_ctl[6] && m_done != 0) ? 1 : 0);
      check(ctl_rdata == m_ctl, "R1", "ctl_rdata", int'(ctl_rdata), int'(m_ctl));
    end
  end

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_wr = 1'b1; data_wdata = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 3000 && m_quiet() == 0; i++) @(negedge clk);
    clks(8);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    clks(4);
    rst = 1'b0;
    clks(1);
    // reset state
    check(ctl_rdata == 8'h00, "R1", "reset ctl", int'(ctl_rdata), 0);
    check(empty == 1'b1, "R4", "reset empty", int'(empty), 1);
    check(done == 1'b1, "R5", "reset done", int'(done), 1);
    check(tx_oe == 1'b0, "R10", "reset oe", int'(tx_oe), 0);
    check(tx_line == 1'b1, "R13", "reset line", int'(tx_line), 1);

    // control readback
    cur_req = "R1";
    wr_ctl(8'hF6);
    check(ctl_rdata == 8'hF6, "R1", "readback", int'(ctl_rdata), 'hF6);
    wr_ctl(8'h00);

    // data waits while disabled
    cur_req = "R6";
    wr_data(8'h3C);
    clks(60);
    check(empty == 1'b0, "R6", "held byte", int'(empty), 0);
    check(tx_line == 1'b1, "R13", "quiet line", int'(tx_line), 1);
    cur_req = "R2";
    wr_ctl(8'h88);
    wait_quiet();
    check(tx_line == 1'b1, "R13", "line after frame", int'(tx_line), 1);

    // back-to-back bytes with complete interrupt
    wr_ctl(8'hC8);
    wr_data(8'hA5);
    for (int i = 0; i < 200 && m_empty == 0; i++) @(negedge clk);
    wr_data(8'h5A);
    wait_quiet();

    // idle queued by enable toggle mid-frame
    cur_req = "R7";
    wr_data(8'h81);
    clks(12);
    wr_ctl(8'hC0);
    wr_ctl(8'hC8);
    wr_data(8'h42);
    wait_quiet();

    // repeating break
    cur_req = "R8";
    wr_ctl(8'h09);
    clks(90);
    check(tx_line == 1'b0, "R8", "break low", int'(tx_line), 0);
    wr_ctl(8'h08);
    wait_quiet();

    // priority break > idle > data
    cur_req = "R9";
    wr_data(8'h11);
    clks(10);
    wr_ctl(8'h00);
    wr_ctl(8'h09);
    wr_ctl(8'h08);
    wr_data(8'h22);
    wait_quiet();

    // pin held after disable until frame ends
    cur_req = "R10";
    wr_data(8'h77);
    clks(8);
    wr_ctl(8'h00);
    check(tx_oe == 1'b1, "R10", "held oe", int'(tx_oe), 1);
    wait_quiet();
    check(tx_oe == 1'b0, "R10", "released oe", int'(tx_oe), 0);

    // loopback
    cur_req = "R11";
    @(negedge clk); mode_loop = 1'b1;
    wr_ctl(8'h08);
    wr_data(8'h55);
    clks(10);
    check(tx_oe == 1'b0, "R11", "loop oe", int'(tx_oe), 0);
    wait_quiet();

    // single wire
    cur_req = "R12";
    @(negedge clk); mode_single = 1'b1; line_dir = 1'b0;
    wr_data(8'hC3);
    clks(10);
    check(tx_oe == 1'b0, "R12", "input dir oe", int'(tx_oe), 0);
    @(negedge clk); line_dir = 1'b1;
    clks(2);
    check(tx_oe == 1'b1, "R12", "output dir oe", int'(tx_oe), 1);
    wait_quiet();
    @(negedge clk); mode_loop = 1'b0; mode_single = 1'b0; line_dir = 1'b0;
    clks(4);
    finish_run();
  end
endmodule